// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block holds the 16-bit status word of a serial receiver and serves it on a small register port at byte offset 0x1A. It accepts single-cycle event strobes from the receive path: completed characters with their parity and stop-bit results, detected start bits, a sync byte in auto-baud framing, collisions and a retry-limit event. It also sees the live clear-to-send pin and a receiver enable. Flags are sticky. Software clears a flag by writing one to its bit.

Parity, stop-bit and overflow results travel with each character through a two-entry receive buffer. A third character can wait in a holding slot. The status read before the data register therefore describes the character that the next data read returns. When a character leaves the buffer, its error bits move into sticky copies. These copies stay set until software clears them. Reading the data register, at byte offset 0x18, pops the head character.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word reads 0x0000 and a data read returns 0 because the buffer is empty.
- R2: Status bits 15..8 and bit 6 always read 0, whatever was written.
- R3: Writing 1 to bit 7, 5, 4, 2, 1 or 0 clears that flag. Writing 0 leaves it unchanged. Bits 15..8 of the write data are ignored.
- R4: Bit 3 reads the cts_pin level while flow_en is 1 and reads 0 otherwise. Writes never change it.
- R5: A character strobed with chr_stop_bad=1 sets bit 1 while that character is at the buffer head.
- R6: chr_par_bad sets bit 0 only when fmt is 1, 5 or 7. Any other fmt value masks it.
- R7: A start_det that arrives while both buffer entries are full and a third character is held marks that held character as overflowed. Bit 2 reads 1 once that character reaches the head. A start_det with no held character marks nothing.
- R8: Bits 0..2 show the head character's own error bits OR'ed with the sticky copies of characters already popped.
- R9: While rx_en is 0, bits 0, 1, 2, 4 and 5 are cleared, and characters, start bits, sync bytes and collisions are ignored. Bit 7 is kept.
- R10: When fmt is 4 or 5, a sync byte other than 0x55 sets bit 4. A sync byte of 0x55, or any other fmt, leaves bit 4 clear.
- R11: coll_evt sets bit 5 only while coll_en is 1.
- R12: retry_evt sets bit 7, and this works even while rx_en is 0.
- R13: A hardware set and a write-one clear to the same bit in the same cycle leave the bit set.
- R14: Data reads return characters in arrival order, including the held third character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| fmt | input | 4 | Frame-format code |
| flow_en | input | 1 | Flow control enable |
| cts_pin | input | 1 | Live clear-to-send level |
| coll_en | input | 1 | Collision detection enable |
| chr_valid | input | 1 | Character completed strobe |
| chr_data | input | 9 | Received character |
| chr_par_bad | input | 1 | Parity mismatch for chr_data |
| chr_stop_bad | input | 1 | First stop bit sampled as 0 |
| start_det | input | 1 | New start bit detected |
| sync_valid | input | 1 | Sync byte received strobe |
| sync_byte | input | 8 | Received sync byte |
| coll_evt | input | 1 | Collision detected strobe |
| retry_evt | input | 1 | Retry limit reached strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |

## Verification
A hardware set and a software write-one clear can land on the same flag in the same cycle. Examples are a collision strobe or retry strobe together with a status write, or a parity-bad character pushed into an empty buffer while bit 0 is being cleared. The bench drives both in one cycle and then reads the flag, which must still be 1. A pop can also coincide with an arriving character and with a release of the held slot. This case is judged by the order of the data reads and by the overflow bit appearing only with the held character.

// File: rtl/uart_rx_status_pkg.sv
`timescale 1ns/1ps
package uart_rx_status_pkg;
    // per-character error bits; packed order matches status bits 2..0
    typedef struct packed {
        logic ovf;
        logic ferr;
        logic perr;
    } err_t;

    localparam int BIT_PERR = 0;
    localparam int BIT_FERR = 1;
    localparam int BIT_OVF  = 2;
    localparam int BIT_CTS  = 3;
    localparam int BIT_ISF  = 4;
    localparam int BIT_COLL = 5;
    localparam int BIT_ITER = 7;
endpackage

// File: rtl/uart_rx_status_fifo.sv
`timescale 1ns/1ps
module uart_rx_status_fifo
    import uart_rx_status_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 2          // power of two, at least 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_v,
    input  logic [DW-1:0] push_data,
    input  err_t          push_err,
    input  logic          pop,
    input  logic          start_det,
    input  err_t          clr_head,
    input  logic          flush_err,
    output logic          head_valid,
    output logic [DW-1:0] head_data,
    output err_t          head_err,
    output err_t          pop_err
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        err_t [DEPTH-1:0]         err;
        logic [DW-1:0]            pend_data;
        err_t                     pend_err;
        logic                     pend_v;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t           st_d, st_q;
    logic          pop_ok, ins;
    logic [PW-1:0] tail;
    err_t          p_err;

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && (st_q.cnt != '0);
        tail   = st_q.rd_ptr + st_q.cnt[PW-1:0];
        ins    = 1'b0;
        p_err  = st_q.pend_err;
        if (start_det && st_q.cnt == CW'(DEPTH) && st_q.pend_v)
            p_err.ovf = 1'b1;
        st_d.pend_err = p_err;
        if (st_q.cnt != '0)
            st_d.err[st_q.rd_ptr] = err_t'(st_q.err[st_q.rd_ptr] & ~clr_head);
        if (pop_ok && st_q.pend_v) begin
            st_d.data[tail] = st_q.pend_data;
            st_d.err[tail]  = p_err;
            ins = 1'b1;
            if (push_v) begin
                st_d.pend_data = push_data;
                st_d.pend_err  = push_err;
            end else begin
                st_d.pend_v   = 1'b0;
                st_d.pend_err = '0;
            end
        end else if (push_v && !st_q.pend_v) begin
            if (st_q.cnt != CW'(DEPTH) || pop_ok) begin
                st_d.data[tail] = push_data;
                st_d.err[tail]  = push_err;
                ins = 1'b1;
            end else begin
                st_d.pend_data = push_data;
                st_d.pend_err  = push_err;
                st_d.pend_v    = 1'b1;
            end
        end
        if (pop_ok)
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        st_d.cnt = st_q.cnt + CW'(ins) - CW'(pop_ok);
        if (flush_err) begin
            st_d.err      = '0;
            st_d.pend_err = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.data[st_q.rd_ptr];
    assign head_err   = st_q.err[st_q.rd_ptr];
    assign pop_err    = pop_ok ? st_q.err[st_q.rd_ptr] : '0;

    // R14: occupancy never exceeds the buffer depth
    a_r14_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R7: overflow mark on the held character only follows a start bit while full
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend_err.ovf) |-> $past(start_det && st_q.pend_v));
endmodule

// File: rtl/uart_rx_status_flags.sv
`timescale 1ns/1ps
module uart_rx_status_flags
    import uart_rx_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic [7:0] clr,
    input  err_t       pop_err,
    input  logic       isf_set,
    input  logic       coll_set,
    input  logic       iter_set,
    output err_t       sticky_err,
    output logic       isf,
    output logic       coll,
    output logic       iter
);
    typedef struct packed {
        err_t s_err;
        logic isf;
        logic coll;
        logic iter;
    } fl_t;

    fl_t  fl_d, fl_q;
    logic unused_clr;
    assign unused_clr = clr[6] ^ clr[3];

    always_comb begin
        fl_d = fl_q;
        // software clear first, hardware set after: set wins
        fl_d.s_err = err_t'(fl_q.s_err & ~clr[2:0]);
        if (clr[BIT_ISF])  fl_d.isf  = 1'b0;
        if (clr[BIT_COLL]) fl_d.coll = 1'b0;
        if (clr[BIT_ITER]) fl_d.iter = 1'b0;
        fl_d.s_err = err_t'(fl_d.s_err | pop_err);
        if (isf_set)  fl_d.isf  = 1'b1;
        if (coll_set) fl_d.coll = 1'b1;
        if (iter_set) fl_d.iter = 1'b1;
        if (!rx_en) begin
            fl_d.s_err = '0;
            fl_d.isf   = 1'b0;
            fl_d.coll  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign sticky_err = fl_q.s_err;
    assign isf        = fl_q.isf;
    assign coll       = fl_q.coll;
    assign iter       = fl_q.iter;

    // R12: retry strobe always lands
    a_r12_retry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        iter_set |=> fl_q.iter);
    // R13: collision set beats a same-cycle clear
    a_r13_coll_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        coll_set |=> fl_q.coll);
    // R9: receiver off wipes receive flags
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!fl_q.isf && !fl_q.coll && fl_q.s_err == '0));
    // R3: writing zero keeps a set flag
    a_r3_keep_iter: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.iter && !clr[BIT_ITER]) |=> fl_q.iter);
endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int          DW       = 9,
    parameter int          DEPTH    = 2,
    parameter int          AW       = 6,
    parameter int          BUS_W    = 16,
    parameter logic [AW-1:0] STAT_OFF = 6'h1A,
    parameter logic [AW-1:0] DATA_OFF = 6'h18,
    parameter logic [7:0]  SYNC_PAT = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [3:0]       fmt,
    input  logic             flow_en,
    input  logic             cts_pin,
    input  logic             coll_en,
    input  logic             chr_valid,
    input  logic [DW-1:0]    chr_data,
    input  logic             chr_par_bad,
    input  logic             chr_stop_bad,
    input  logic             start_det,
    input  logic             sync_valid,
    input  logic [7:0]       sync_byte,
    input  logic             coll_evt,
    input  logic             retry_evt,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    logic          par_on, autobaud, stat_wr, data_rd, stat_rd;
    logic [7:0]    clr;
    err_t          push_err, clr_head, head_err, pop_err, sticky_err;
    logic          head_valid, isf, coll, iter;
    logic [DW-1:0] head_data;
    logic [7:0]    stat;
    logic          unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:8];
    assign par_on    = (fmt == 4'd1) || (fmt == 4'd5) || (fmt == 4'd7);
    assign autobaud  = (fmt == 4'd4) || (fmt == 4'd5);
    assign stat_wr   = bus_sel && bus_wr && (bus_addr == STAT_OFF);
    assign stat_rd   = bus_sel && !bus_wr && (bus_addr == STAT_OFF);
    assign data_rd   = bus_sel && !bus_wr && (bus_addr == DATA_OFF);
    assign clr       = stat_wr ? bus_wdata[7:0] : 8'h00;
    assign clr_head  = err_t'(clr[2:0]);
    assign push_err  = '{ovf: 1'b0, ferr: chr_stop_bad, perr: chr_par_bad && par_on};

    uart_rx_status_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_v     (chr_valid && rx_en),
        .push_data  (chr_data),
        .push_err   (push_err),
        .pop        (data_rd),
        .start_det  (start_det && rx_en),
        .clr_head   (clr_head),
        .flush_err  (!rx_en),
        .head_valid (head_valid),
        .head_data  (head_data),
        .head_err   (head_err),
        .pop_err    (pop_err)
    );

    uart_rx_status_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .clr        (clr),
        .pop_err    (pop_err),
        .isf_set    (sync_valid && rx_en && autobaud && (sync_byte != SYNC_PAT)),
        .coll_set   (coll_evt && coll_en && rx_en),
        .iter_set   (retry_evt),
        .sticky_err (sticky_err),
        .isf        (isf),
        .coll       (coll),
        .iter       (iter)
    );

    always_comb begin
        stat = '0;
        stat[BIT_PERR] = sticky_err.perr | (head_valid & head_err.perr);
        stat[BIT_FERR] = sticky_err.ferr | (head_valid & head_err.ferr);
        stat[BIT_OVF]  = sticky_err.ovf  | (head_valid & head_err.ovf);
        stat[BIT_CTS]  = flow_en & cts_pin;
        stat[BIT_ISF]  = isf;
        stat[BIT_COLL] = coll;
        stat[BIT_ITER] = iter;
    end

    always_comb begin
        bus_rdata = '0;
        if (stat_rd)
            bus_rdata = {{(BUS_W-8){1'b0}}, stat};
        else if (data_rd && head_valid)
            bus_rdata = {{(BUS_W-DW){1'b0}}, head_data};
    end

    // R5: a stop-bit error pushed into an empty buffer shows next cycle
    a_r5_ferr_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && chr_valid && chr_stop_bad && !head_valid) |=> stat[BIT_FERR]);
    // R4: status read reports the pin while flow control is on
    a_r4_cts_view: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && flow_en) |-> (bus_rdata[BIT_CTS] == cts_pin));
endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, flow_en = 1'b0, cts_pin = 1'b0, coll_en = 1'b0;
    logic [3:0]  fmt = '0;
    logic        chr_valid = 1'b0, chr_par_bad = 1'b0, chr_stop_bad = 1'b0;
    logic [8:0]  chr_data = '0;
    logic        start_det = 1'b0, sync_valid = 1'b0, coll_evt = 1'b0, retry_evt = 1'b0;
    logic [7:0]  sync_byte = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] STAT = 6'h1A;
    localparam logic [5:0] DATA = 6'h18;

    always #2.5 clk = ~clk;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fmt(fmt), .flow_en(flow_en),
        .cts_pin(cts_pin), .coll_en(coll_en), .chr_valid(chr_valid),
        .chr_data(chr_data), .chr_par_bad(chr_par_bad), .chr_stop_bad(chr_stop_bad),
        .start_det(start_det), .sync_valid(sync_valid), .sync_byte(sync_byte),
        .coll_evt(coll_evt), .retry_evt(retry_evt), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic peek(output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = STAT;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr_stat(input logic [15:0] w);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = STAT; bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_data(output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = DATA;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [8:0] d, input logic pb, input logic sb);
        chr_valid = 1'b1; chr_data = d; chr_par_bad = pb; chr_stop_bad = sb;
        @(negedge clk);
        chr_valid = 1'b0; chr_par_bad = 1'b0; chr_stop_bad = 1'b0;
    endtask

    task automatic sync(input logic [7:0] b);
        sync_valid = 1'b1; sync_byte = b;
        @(negedge clk);
        sync_valid = 1'b0;
    endtask

    task automatic start_bit();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(v);    chk("R1 status", v, 16'h0000);
        rd_data(v); chk("R1 empty data", v, 16'h0000);
        rx_en = 1'b1;

        // R6 parity gating over every fmt code
        for (int f = 0; f < 16; f++) begin
            fmt = f[3:0];
            push(9'h0AA, 1'b1, 1'b0);
            peek(v);
            chk("R6 parity gate", v, (f == 1 || f == 5 || f == 7) ? 16'h0001 : 16'h0000);
            rd_data(v); chk("R6 data", v, 16'h00AA);
            wr_stat(16'h00FF);
        end

        // R10 sync check over fmt codes and byte values
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] b;
                b = (k == 0) ? 8'h55 : (k == 1) ? 8'h54 : (k == 2) ? 8'hD5 : (k == 3) ? 8'h00 : 8'hFF;
                fmt = f[3:0];
                sync(b);
                peek(v);
                chk("R10 sync", v, ((f == 4 || f == 5) && b != 8'h55) ? 16'h0010 : 16'h0000);
                wr_stat(16'h0010);
            end
        end

        // R11 collision enable
        coll_en = 1'b0; coll_evt = 1'b1; @(negedge clk); coll_evt = 1'b0;
        peek(v); chk("R11 coll masked", v, 16'h0000);
        coll_en = 1'b1; coll_evt = 1'b1; @(negedge clk); coll_evt = 1'b0;
        peek(v); chk("R11 coll set", v, 16'h0020);
        wr_stat(16'h0020);

        // R4 clear-to-send view, and writes have no effect
        for (int fe = 0; fe < 2; fe++) begin
            for (int c = 0; c < 2; c++) begin
                flow_en = fe[0]; cts_pin = c[0];
                wr_stat(16'hFFFF);
                peek(v); chk("R4 cts", v, (fe == 1 && c == 1) ? 16'h0008 : 16'h0000);
            end
        end
        flow_en = 1'b0; cts_pin = 1'b0;

        // R3 / R2 write-one-clear sweep over all low-byte masks
        fmt = 4'd5;
        for (int m = 0; m < 256; m++) begin
            retry_evt = 1'b1; coll_evt = 1'b1; sync_valid = 1'b1; sync_byte = 8'h00;
            chr_valid = 1'b1; chr_data = 9'h1F0; chr_par_bad = 1'b1; chr_stop_bad = 1'b1;
            @(negedge clk);
            retry_evt = 1'b0; coll_evt = 1'b0; sync_valid = 1'b0;
            chr_valid = 1'b0; chr_par_bad = 1'b0; chr_stop_bad = 1'b0;
            peek(v); chk("R3 set all", v, 16'h00B3);
            wr_stat({8'hFF, m[7:0]});
            peek(v); chk("R3 R2 masked clear", v, 16'h00B3 & ~{8'h00, m[7:0]});
            rd_data(v);
            wr_stat(16'h00FF);
            peek(v); chk("R3 all clear", v, 16'h0000);
        end
        fmt = 4'd0;

        // R8 flags follow the head character, sticky after pop
        push(9'h101, 1'b0, 1'b0);
        push(9'h102, 1'b0, 1'b1);
        peek(v); chk("R8 clean head", v, 16'h0000);
        rd_data(v); chk("R14 first", v, 16'h0101);
        peek(v); chk("R5 R8 ferr head", v, 16'h0002);
        rd_data(v); chk("R14 second", v, 16'h0102);
        peek(v); chk("R8 sticky ferr", v, 16'h0002);
        wr_stat(16'h0002);
        peek(v); chk("R8 cleared", v, 16'h0000);

        // R7 overflow on held third character, R14 order
        push(9'h1A5, 1'b0, 1'b0);
        push(9'h0C3, 1'b0, 1'b0);
        push(9'h155, 1'b0, 1'b0);
        start_bit();
        peek(v); chk("R7 head A clean", v, 16'h0000);
        rd_data(v); chk("R14 A", v, 16'h01A5);
        peek(v); chk("R7 head B clean", v, 16'h0000);
        rd_data(v); chk("R14 B", v, 16'h00C3);
        peek(v); chk("R7 ovf on C", v, 16'h0004);
        rd_data(v); chk("R14 C", v, 16'h0155);
        wr_stat(16'h0004);
        // R7 full buffer without held character: no overflow
        push(9'h011, 1'b0, 1'b0);
        push(9'h022, 1'b0, 1'b0);
        start_bit();
        rd_data(v); chk("R14 D", v, 16'h0011);
        rd_data(v); chk("R14 E", v, 16'h0022);
        peek(v); chk("R7 no ovf", v, 16'h0000);

        // R9 disable clears receive flags, keeps retry, ignores events
        fmt = 4'd4;
        push(9'h033, 1'b0, 1'b1);
        rd_data(v);
        coll_evt = 1'b1; @(negedge clk); coll_evt = 1'b0;
        sync(8'h12);
        retry_evt = 1'b1; @(negedge clk); retry_evt = 1'b0;
        peek(v); chk("R9 before", v, 16'h00B2);
        rx_en = 1'b0;
        coll_evt = 1'b1; chr_valid = 1'b1; chr_data = 9'h044; chr_stop_bad = 1'b1;
        @(negedge clk);
        coll_evt = 1'b0; chr_valid = 1'b0; chr_stop_bad = 1'b0;
        peek(v); chk("R9 off", v, 16'h0080);
        // R12 retry lands while disabled
        wr_stat(16'h0080);
        retry_evt = 1'b1; @(negedge clk); retry_evt = 1'b0;
        peek(v); chk("R12 retry off", v, 16'h0080);
        rx_en = 1'b1;
        rd_data(v); chk("R9 nothing pushed", v, 16'h0000);
        wr_stat(16'h0080);

        // R13 same-cycle set and clear
        coll_evt = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 16'h0020;
        @(negedge clk);
        coll_evt = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        peek(v); chk("R13 coll wins", v, 16'h0020);
        wr_stat(16'h0020);
        retry_evt = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 16'h0080;
        @(negedge clk);
        retry_evt = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        peek(v); chk("R13 retry wins", v, 16'h0080);
        wr_stat(16'h0080);
        fmt = 4'd1;
        chr_valid = 1'b1; chr_data = 9'h077; chr_par_bad = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 16'h0001;
        @(negedge clk);
        chr_valid = 1'b0; chr_par_bad = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        peek(v); chk("R13 parity wins", v, 16'h0001);
        rd_data(v); chk("R14 parity char", v, 16'h0077);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule